// File: doc/BRIEF.md
# Three-Share Masked Linear Unit

This block performs the linear operations of an add-rotate-xor datapath on secret words. Each secret word is held as three Boolean shares, and the word is the XOR of the three. The unit processes each share on its own and never combines them, so no internal signal carries the unmasked secret. It supports three operations. The first XORs two shared operands. The second XORs a shared operand with a public word. The third rotates a shared operand left or right by a public amount.

A caller presents an opcode, two shared operands, a public word, a rotation amount and a direction bit, and raises the input-valid signal. One clock later the registered three-share result appears, and the output-valid signal is high for that cycle. The public XOR changes only the third share. The rotation amount is never masked, so the caller must only supply amounts that do not depend on secret data.

Top module: `mlin_unit`

## Requirements
- R1: With `op_i` = 2'b00 (share XOR), result share k equals `a_sh_i` share k XOR `b_sh_i` share k, for k = 0, 1, 2. Share k occupies bits [32k+31:32k] of a 96-bit share bus.
- R2: With `op_i` = 2'b01 (public XOR), result shares 0 and 1 equal `a_sh_i` shares 0 and 1 unchanged, and result share 2 equals `a_sh_i` share 2 XOR `pub_i`.
- R3: With `op_i` = 2'b10 (rotate), every result share is the matching `a_sh_i` share rotated by `rot_amt_i`. The rotation is left when `rot_dir_i` = 0 and right when `rot_dir_i` = 1.
- R4: In every operation, the XOR of the three result shares equals the unmasked result of the same operation on the recombined operands.
- R5: `res_vld_o` is high exactly one cycle after `in_vld_i` is high, and `res_sh_o` is updated in that same cycle.
- R6: When `in_vld_i` is low, `res_sh_o` keeps its previous value. Opcode 2'b11 is reserved: it loads the shared operand `a_sh_i` through unchanged.
- R7: While `rst_n` is low, `res_vld_o` is 0 and `res_sh_o` is all zeros.
- R8: A rotation by 0 returns every share unchanged, whichever direction is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld_i | input | 1 | Operation request |
| op_i | input | 2 | Opcode: 00 share XOR, 01 public XOR, 10 rotate, 11 pass |
| a_sh_i | input | 96 | First operand, three 32-bit shares |
| b_sh_i | input | 96 | Second operand, three 32-bit shares |
| pub_i | input | 32 | Public word for the public XOR |
| rot_amt_i | input | 5 | Public rotation amount |
| rot_dir_i | input | 1 | Rotation direction: 0 left, 1 right |
| res_vld_o | output | 1 | Result valid |
| res_sh_o | output | 96 | Registered three-share result |

## Verification
The assertions assume that the inputs are stable and known at each rising edge where `in_vld_i` is high. They compare each registered share against the inputs captured one cycle earlier, so they also rely on no reset occurring between a request and its result. The bench drives its inputs on the falling edge and holds them through the next rising edge. It releases reset only once, before any request, and leaves gaps with `in_vld_i` low so that the hold behaviour can be checked. Shares are random, and the rotation sweep covers all 32 amounts in both directions.

// File: rtl/mlin_pkg.sv
package mlin_pkg;
  parameter int unsigned WORD_W  = 32;
  parameter int unsigned N_SHARE = 3;
  localparam int unsigned ROT_W  = $clog2(WORD_W);
  localparam int unsigned BUS_W  = WORD_W * N_SHARE;

  typedef enum logic [1:0] {
    OP_SXOR = 2'b00,
    OP_PXOR = 2'b01,
    OP_ROT  = 2'b10,
    OP_PASS = 2'b11
  } mlin_op_e;
endpackage

// File: rtl/mlin_rot.sv
module mlin_rot #(
  parameter int unsigned W  = 32,
  localparam int unsigned RW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [RW-1:0] amt,
  input  logic          dir_right,
  output logic [W-1:0]  dout
);
  logic [RW-1:0] eff_amt;
  logic [W-1:0]  stage [RW+1];

  // A right rotation by s is a left rotation by W-s (mod W).
  always_comb eff_amt = dir_right ? RW'(W - {1'b0, amt}) : amt;

  assign stage[0] = din;
  for (genvar s = 0; s < RW; s++) begin : g_stage
    localparam int unsigned SH = 1 << s;
    assign stage[s+1] = eff_amt[s] ? {stage[s][W-1-SH:0], stage[s][W-1:W-SH]} : stage[s];
  end
  assign dout = stage[RW];
endmodule

// File: rtl/mlin_lane.sv
module mlin_lane #(
  parameter int unsigned W      = 32,
  parameter bit          PUB_EN = 1'b0,
  localparam int unsigned RW    = $clog2(W)
) (
  input  mlin_pkg::mlin_op_e op,
  input  logic [W-1:0]       a,
  input  logic [W-1:0]       b,
  input  logic [W-1:0]       pub,
  input  logic [RW-1:0]      amt,
  input  logic               dir_right,
  output logic [W-1:0]       y
);
  logic [W-1:0] rot_y;

  mlin_rot #(.W(W)) u_rot (
    .din(a), .amt(amt), .dir_right(dir_right), .dout(rot_y)
  );

  always_comb begin
    unique case (op)
      mlin_pkg::OP_SXOR: y = a ^ b;
      mlin_pkg::OP_PXOR: y = PUB_EN ? (a ^ pub) : a;
      mlin_pkg::OP_ROT:  y = rot_y;
      default:           y = a;
    endcase
  end
endmodule

// File: rtl/mlin_unit.sv
module mlin_unit
  import mlin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld_i,
  input  logic [1:0]        op_i,
  input  logic [BUS_W-1:0]  a_sh_i,
  input  logic [BUS_W-1:0]  b_sh_i,
  input  logic [WORD_W-1:0] pub_i,
  input  logic [ROT_W-1:0]  rot_amt_i,
  input  logic              rot_dir_i,
  output logic              res_vld_o,
  output logic [BUS_W-1:0]  res_sh_o
);
  mlin_op_e   op;
  logic [BUS_W-1:0] res_d, res_q;
  logic             vld_q;

  always_comb op = mlin_op_e'(op_i);

  // One lane per share. Only the last lane sees the public word.
  for (genvar k = 0; k < N_SHARE; k++) begin : g_lane
    mlin_lane #(.W(WORD_W), .PUB_EN(k == N_SHARE - 1)) u_lane (
      .op       (op),
      .a        (a_sh_i[k*WORD_W +: WORD_W]),
      .b        (b_sh_i[k*WORD_W +: WORD_W]),
      .pub      (pub_i),
      .amt      (rot_amt_i),
      .dir_right(rot_dir_i),
      .y        (res_d[k*WORD_W +: WORD_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= in_vld_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        res_q <= '0;
    else if (in_vld_i) res_q <= res_d;
  end

  assign res_vld_o = vld_q;
  assign res_sh_o  = res_q;
endmodule

// File: rtl/mlin_unit_chk.sv
module mlin_unit_chk
  import mlin_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld_i,
  input logic [1:0]        op_i,
  input logic [BUS_W-1:0]  a_sh_i,
  input logic [BUS_W-1:0]  b_sh_i,
  input logic [WORD_W-1:0] pub_i,
  input logic [ROT_W-1:0]  rot_amt_i,
  input logic              rot_dir_i,
  input logic              res_vld_o,
  input logic [BUS_W-1:0]  res_sh_o
);
  localparam int unsigned W = WORD_W;

  a_r5_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld_i |=> res_vld_o);

  a_r5_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_i |=> !res_vld_o);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_i |=> $stable(res_sh_o));

  a_r1_share_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && op_i == 2'b00) |=> res_sh_o == ($past(a_sh_i) ^ $past(b_sh_i)));

  a_r2_low_shares: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && op_i == 2'b01) |=> res_sh_o[2*W-1:0] == $past(a_sh_i[2*W-1:0]));

  a_r4_pub_recombine: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && op_i == 2'b01) |=>
      (res_sh_o[W-1:0] ^ res_sh_o[2*W-1:W] ^ res_sh_o[3*W-1:2*W]) ==
      ($past(a_sh_i[W-1:0]) ^ $past(a_sh_i[2*W-1:W]) ^ $past(a_sh_i[3*W-1:2*W]) ^ $past(pub_i)));

  a_r8_rot_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld_i && op_i == 2'b10 && rot_amt_i == '0) |=> res_sh_o == $past(a_sh_i));

  always_comb begin
    if (!rst_n) a_r7_reset: assert (res_vld_o == 1'b0 && res_sh_o == '0);
  end
endmodule

bind mlin_unit mlin_unit_chk u_chk (.*);

// File: tb/mlin_unit_tb_top.sv
module mlin_unit_tb_top;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_vld_i;
  logic [1:0]  op_i;
  logic [95:0] a_sh_i, b_sh_i;
  logic [31:0] pub_i;
  logic [4:0]  rot_amt_i;
  logic        rot_dir_i;
  logic        res_vld_o;
  logic [95:0] res_sh_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  mlin_unit dut_i (.*);

  function automatic logic [31:0] rotl(logic [31:0] v, int s);
    return (s == 0) ? v : ((v << s) | (v >> (32 - s)));
  endfunction

  function automatic logic [31:0] rec(logic [95:0] v);
    return v[31:0] ^ v[63:32] ^ v[95:64];
  endfunction

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rnd96(output logic [95:0] v);
    v = {$urandom, $urandom, $urandom};
  endtask

  // Drive on the falling edge and check the result one rising edge later.
  task automatic issue(logic [1:0] op, logic [4:0] amt, logic dir);
    @(negedge clk);
    in_vld_i  = 1'b1;
    op_i      = op;
    rot_amt_i = amt;
    rot_dir_i = dir;
    @(negedge clk);
    in_vld_i  = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [95:0] exp;
    logic [95:0] held;
    logic [31:0] r;

    rst_n     = 1'b0;
    in_vld_i  = 1'b0;
    op_i      = 2'b00;
    a_sh_i    = '0;
    b_sh_i    = '0;
    pub_i     = '0;
    rot_amt_i = '0;
    rot_dir_i = 1'b0;

    #12;
    chk("R7", {95'b0, res_vld_o}, 96'd0);
    chk("R7", res_sh_o, 96'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 share XOR and R4 recombination
    for (int i = 0; i < 20; i++) begin
      rnd96(a_sh_i);
      rnd96(b_sh_i);
      issue(2'b00, 5'd0, 1'b0);
      chk("R5", {95'b0, res_vld_o}, 96'd1);
      chk("R1", res_sh_o, a_sh_i ^ b_sh_i);
      chk("R4", {64'b0, rec(res_sh_o)}, {64'b0, rec(a_sh_i) ^ rec(b_sh_i)});
    end

    // R2 public XOR touches only the third share
    for (int i = 0; i < 20; i++) begin
      rnd96(a_sh_i);
      pub_i = $urandom;
      issue(2'b01, 5'd0, 1'b0);
      exp = {a_sh_i[95:64] ^ pub_i, a_sh_i[63:0]};
      chk("R2", res_sh_o, exp);
      chk("R4", {64'b0, rec(res_sh_o)}, {64'b0, rec(a_sh_i) ^ pub_i});
    end

    // R3 and R8: all 32 amounts in both directions
    for (int d = 0; d < 2; d++) begin
      for (int s = 0; s < 32; s++) begin
        rnd96(a_sh_i);
        issue(2'b10, 5'(s), d[0]);
        for (int k = 0; k < 3; k++) begin
          r = (d == 0) ? rotl(a_sh_i[k*32 +: 32], s) : rotl(a_sh_i[k*32 +: 32], (32 - s) % 32);
          exp[k*32 +: 32] = r;
        end
        if (s == 0) chk("R8", res_sh_o, a_sh_i);
        else        chk("R3", res_sh_o, exp);
        chk("R4", {64'b0, rec(res_sh_o)},
            {64'b0, (d == 0) ? rotl(rec(a_sh_i), s) : rotl(rec(a_sh_i), (32 - s) % 32)});
      end
    end

    // R6 reserved opcode passes the shared operand through
    rnd96(a_sh_i);
    rnd96(b_sh_i);
    issue(2'b11, 5'd3, 1'b0);
    chk("R6", res_sh_o, a_sh_i);

    // R6 hold and R5: no request means no valid and no change
    held = res_sh_o;
    rnd96(a_sh_i);
    rnd96(b_sh_i);
    op_i = 2'b00;
    @(negedge clk);
    @(negedge clk);
    chk("R5", {95'b0, res_vld_o}, 96'd0);
    chk("R6", res_sh_o, held);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule